// File: doc/BRIEF.md
# Minimal Accumulator Processor Core

A stored-program processor built around one register, the accumulator. Code and data share one memory of words as wide as the accumulator, so a program can rewrite its own instructions. Each instruction word holds an opcode and an absolute address. The core executes five operations: load, store, clear, increment, and a branch that is taken only when the accumulator is zero. That branch is the only control-flow primitive. Loops and unconditional jumps are built from it, and indirect access comes from programs that rewrite their own code.

The core drives a synchronous single-port memory. An address presented in one cycle returns its word on the read port in the next cycle, and a write takes effect at the clock edge. The program counter and the accumulator are visible as debug outputs. The memory is preloaded from outside, and execution starts at word 0 after reset.

Top module: `macc_core`

## Requirements
- R1: While rst_ni is low, pc_o and acc_o read 0 and mem_we_o is 0. The first fetch after reset presents address 0 on mem_addr_o.
- R2: Word layout: bits [11:9] hold the opcode (000 load, 001 store, 010 clear, 011 increment, 100 branch-if-zero) and bits [8:0] hold the absolute address. Each instruction takes a fetch cycle and then an execute cycle. A load adds one data-read cycle, for 3 cycles in total. In the execute cycle of a load or store, mem_addr_o carries the address field.
- R3: A load copies the addressed memory word into the accumulator.
- R4: A store writes the accumulator into the addressed word with a single-cycle mem_we_o pulse and leaves the accumulator unchanged.
- R5: Clear sets the accumulator to 0.
- R6: Increment adds one modulo 2^12, so 12'hFFF becomes 12'h000.
- R7: Branch-if-zero sets the program counter to the address field when the accumulator is 0, and to the next sequential word otherwise.
- R8: Opcodes 101, 110 and 111 leave the accumulator and memory unchanged and advance the program counter by one.
- R9: The program counter wraps from word MEM_DEPTH-1 (511) to word 0.
- R10: A store into a word that executes later, including the very next word, changes what executes there.
- R11: mem_we_o is asserted only during the execute cycle of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 9 | Memory word address |
| mem_wdata_o | output | 12 | Memory write data (the accumulator) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 12 | Memory read data, one cycle after the address |
| pc_o | output | 9 | Debug view of the program counter |
| acc_o | output | 12 | Debug view of the accumulator |

## Verification
Every cycle, the assertions check the phase order and the single-cycle write pulse. They also check the local update rules: the increment wrap, clear, the accumulator held by non-arithmetic opcodes, load data captured from the read port, and the branch and wrap rules for the program counter. Only the bench's programs can show whole-program effects. These are a stored word being fetched later as an instruction, a jump through a branch across the end of memory, and the final memory image matching an instruction-level model over random code that overwrites itself.

// File: rtl/macc_pkg.sv
package macc_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_LOAD  = 3'b000;
  localparam logic [OP_W-1:0] OP_STORE = 3'b001;
  localparam logic [OP_W-1:0] OP_CLR   = 3'b010;
  localparam logic [OP_W-1:0] OP_INC   = 3'b011;
  localparam logic [OP_W-1:0] OP_BRZ   = 3'b100;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_LOAD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic ld;
    logic st;
    logic clr;
    logic inc;
    logic brz;
  } dec_t;
endpackage

// File: rtl/macc_decode.sv
module macc_decode
  import macc_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int ADDR_W = DATA_W - OP_W
) (
  input  logic [DATA_W-1:0] word_i,
  output dec_t              dec_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [OP_W-1:0] op;

  assign op     = word_i[DATA_W-1 -: OP_W];
  assign addr_o = word_i[ADDR_W-1:0];

  always_comb begin
    dec_o = '0;
    unique case (op)
      OP_LOAD:  dec_o.ld  = 1'b1;
      OP_STORE: dec_o.st  = 1'b1;
      OP_CLR:   dec_o.clr = 1'b1;
      OP_INC:   dec_o.inc = 1'b1;
      OP_BRZ:   dec_o.brz = 1'b1;
      default:  dec_o     = '0;  // unused codes: no-op
    endcase
  end

  always_comb begin
    assert ($onehot0(dec_o)) else $error("AST_DEC_ONEHOT"); // R2
  end
endmodule

// File: rtl/macc_seq.sv
module macc_seq
  import macc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ld_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH: phase_d = PH_EXEC;
      PH_EXEC:  phase_d = ld_i ? PH_LOAD : PH_FETCH;
      default:  phase_d = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  AST_FETCH_TO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_FETCH |=> phase_q == PH_EXEC); // R2
  AST_LOAD_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_LOAD |=> phase_q == PH_FETCH); // R2
  AST_LOAD_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EXEC && ld_i) |=> phase_q == PH_LOAD); // R2
endmodule

// File: rtl/macc_pc.sv
module macc_pc #(
  parameter int ADDR_W    = 9,
  parameter int MEM_DEPTH = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] PC_LAST = ADDR_W'(MEM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] PC_ONE  = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_seq;

  assign pc_seq = (pc_q == PC_LAST) ? '0 : pc_q + PC_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (step_i) pc_q <= take_i ? target_i : pc_seq;
  end

  assign pc_o = pc_q;

  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_q)); // R2
  AST_PC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !take_i && pc_q == PC_LAST) |=> pc_q == '0); // R9
  AST_PC_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !take_i && pc_q != PC_LAST) |=> pc_q == $past(pc_q) + PC_ONE); // R7
  AST_PC_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && take_i) |=> pc_q == $past(target_i)); // R7
endmodule

// File: rtl/macc_acc.sv
module macc_acc
  import macc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  dec_t              dec_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] acc_o
);
  localparam logic [DATA_W-1:0] ACC_ONE = DATA_W'(1);

  logic [DATA_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (exec_i) begin
      if (dec_i.clr)      acc_q <= '0;
      else if (dec_i.inc) acc_q <= acc_q + ACC_ONE;
    end else if (load_i) begin
      acc_q <= rdata_i;
    end
  end

  assign acc_o = acc_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && dec_i.clr) |=> acc_q == '0); // R5
  AST_INC_MOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && dec_i.inc) |=> acc_q == $past(acc_q) + ACC_ONE); // R6
  AST_ACC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !dec_i.clr && !dec_i.inc) |=> $stable(acc_q)); // R8
  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_q == $past(rdata_i)); // R3
endmodule

// File: rtl/macc_core.sv
module macc_core
  import macc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int MEM_DEPTH = 512,
  localparam int ADDR_W   = DATA_W - OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o
);
  phase_e            phase;
  dec_t              dec;
  logic [ADDR_W-1:0] field;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] acc;
  logic              exec;
  logic              take;

  // in the execute phase the read port carries the instruction word
  macc_decode #(.DATA_W(DATA_W)) i_decode (
    .word_i (mem_rdata_i),
    .dec_o  (dec),
    .addr_o (field)
  );

  macc_seq i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (dec.ld),
    .phase_o (phase)
  );

  assign exec = (phase == PH_EXEC);
  assign take = dec.brz && (acc == '0);

  macc_pc #(.ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)) i_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (exec),
    .take_i   (take),
    .target_i (field),
    .pc_o     (pc)
  );

  macc_acc #(.DATA_W(DATA_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .exec_i  (exec),
    .dec_i   (dec),
    .load_i  (phase == PH_LOAD),
    .rdata_i (mem_rdata_i),
    .acc_o   (acc)
  );

  assign mem_addr_o  = exec ? field : pc;
  assign mem_wdata_o = acc;
  assign mem_we_o    = exec && dec.st;
  assign pc_o        = pc;
  assign acc_o       = acc;

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o && phase == PH_FETCH); // R4
  AST_STORE_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> acc == $past(mem_wdata_o)); // R4
  AST_WE_EXEC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase != PH_EXEC |-> !mem_we_o); // R11
endmodule

// File: tb/test_macc_core.sv
module test_macc_core;
  localparam int DW = 12;
  localparam int AW = 9;
  localparam int DEPTH = 512;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] pc;
  logic [DW-1:0] acc;

  logic [DW-1:0] dmem [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] rpc;
  logic [DW-1:0] racc;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  macc_core i_macc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_rdata_i (mem_rdata),
    .pc_o        (pc),
    .acc_o       (acc)
  );

  always @(posedge clk) begin
    if (mem_we) dmem[mem_addr] <= mem_wdata;
    mem_rdata <= dmem[mem_addr];
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog R2 actual=%0d cycles expected=completion", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(input logic [2:0] op, input logic [AW-1:0] a);
    return {op, a};
  endfunction

  task automatic put(input int a, input logic [DW-1:0] w);
    dmem[a] <= w;
    ref_mem[a] = w;
  endtask

  // instruction-level reference model
  task automatic iss_step(output int cyc, output logic [2:0] op, output logic [AW-1:0] f,
                          output bit taken, output bit wrapped, output bit did_st);
    logic [DW-1:0] w;
    logic [AW-1:0] nxt;
    w = ref_mem[rpc];
    op = w[11:9];
    f = w[8:0];
    cyc = 2;
    taken = 1'b0;
    did_st = 1'b0;
    wrapped = (rpc == AW'(DEPTH - 1));
    nxt = wrapped ? '0 : rpc + AW'(1);
    case (op)
      3'b000: begin racc = ref_mem[f]; cyc = 3; end
      3'b001: begin ref_mem[f] = racc; did_st = 1'b1; end
      3'b010: racc = '0;
      3'b011: racc = racc + DW'(1);
      3'b100: if (racc == '0) begin nxt = f; taken = 1'b1; wrapped = 1'b0; end
      default: ;
    endcase
    rpc = nxt;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pc == '0 && acc == '0 && !mem_we, "R1", "reset state pc/acc/we",
        {pc, acc, 3'(mem_we)}, 32'h0);
    rpc = '0;
    racc = '0;
    rst_ni = 1'b1;
    #1;
    chk(mem_addr == '0, "R1", "first fetch address", 32'(mem_addr), 32'h0);
  endtask

  task automatic run(input int nsteps);
    int cyc;
    logic [2:0] op;
    logic [AW-1:0] f;
    bit taken, wrapped, did_st;
    int we_cnt;
    logic [AW-1:0] cur_pc;
    bit last_st;
    logic [AW-1:0] last_st_addr;
    string tag;
    last_st = 1'b0;
    last_st_addr = '0;
    for (int s = 0; s < nsteps; s++) begin
      cur_pc = rpc;
      iss_step(cyc, op, f, taken, wrapped, did_st);
      we_cnt = 0;
      for (int c = 0; c < cyc; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (mem_we) we_cnt++;
        if (c == 0 && (op == 3'b000 || op == 3'b001))
          chk(mem_addr == f, "R2", "address field on memory port", 32'(mem_addr), 32'(f));
      end
      if (wrapped) tag = "R9";
      else if (last_st && last_st_addr == cur_pc) tag = "R10";
      else case (op)
        3'b000: tag = "R3";
        3'b001: tag = "R4";
        3'b010: tag = "R5";
        3'b011: tag = "R6";
        3'b100: tag = "R7";
        default: tag = "R8";
      endcase
      chk(pc == rpc && acc == racc, tag, "pc/acc after instruction",
          {8'h0, pc, acc}, {8'h0, rpc, racc});
      chk(we_cnt == (did_st ? 1 : 0), "R11", "write pulses per instruction",
          32'(we_cnt), did_st ? 32'd1 : 32'd0);
      if (did_st)
        chk(dmem[f] == ref_mem[f], "R4", "stored word", 32'(dmem[f]), 32'(ref_mem[f]));
      last_st = did_st;
      last_st_addr = f;
    end
  endtask

  task automatic cmp_mem();
    int bad;
    int first;
    bad = 0;
    first = -1;
    for (int i = 0; i < DEPTH; i++)
      if (dmem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, "R10", "final memory image mismatched words", 32'(bad), 32'h0);
    if (first >= 0)
      $display("  first mismatch at word %0d", first);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // directed: increment wrap, branch to high memory, pc wrap, self-modifying code
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) put(i, '0);
    put(0,   enc(3'b000, 9'd20));   // load FFF
    put(1,   enc(3'b011, 9'd0));    // inc -> 0 (R6)
    put(2,   enc(3'b100, 9'd510));  // taken first time, not later
    put(3,   enc(3'b010, 9'd0));
    put(4,   enc(3'b111, 9'd5));    // unused opcode (R8)
    put(5,   enc(3'b101, 9'd0));    // unused opcode (R8)
    put(6,   enc(3'b100, 9'd8));
    put(8,   enc(3'b001, 9'd9));    // overwrite next word with 0 = load 0
    put(9,   enc(3'b011, 9'd0));
    put(10,  enc(3'b001, 9'd22));
    put(20,  12'hFFF);
    put(21,  enc(3'b011, 9'd0));
    put(510, enc(3'b000, 9'd21));
    put(511, enc(3'b001, 9'd0));    // rewrite word 0, then wrap (R9, R10)
    do_reset();
    run(16);
    cmp_mem();

    // directed: 110 must not alter memory or accumulator
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) put(i, enc(3'b110, AW'(i)));
    put(0, enc(3'b011, 9'd0));
    do_reset();
    run(6);
    cmp_mem();

    // random programs confined to a small window, so stores hit code
    for (int p = 0; p < 24; p++) begin
      rst_ni = 1'b0;
      for (int i = 0; i < DEPTH; i++)
        put(i, {3'($urandom_range(0, 7)), 3'b000, 6'($urandom_range(0, 63))});
      do_reset();
      run(150);
      cmp_mem();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule